// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2-style SDRAM and drives its command bus through the power-up programming sequence. After reset it holds clock-enable low and waits for a start pulse. When the pulse arrives it raises clock-enable and holds the bus idle for a programmable number of cycles. It then issues eleven commands in a fixed order. They are two precharge-all commands, writes to the three extended mode registers and the main mode register, two auto refreshes, and a pair of extended writes that set and then leave the output-driver calibration default. Each command is followed by its own programmable gap.

The mode-register payloads come in from outside as address-width words. The block applies its own field overrides to each word: the DLL-reset bit, the test-mode bit, the top address bit, the DLL-disable bit and the three-bit driver-calibration field. It does this so that software-supplied words cannot break the sequence. A separate lock counter, started by the mode write that resets the DLL, holds back the done flag until the DLL has had its fixed lock time. On-die termination stays low throughout. Every output is registered.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, and until start is seen, cke, odt and done are low, the bus shows NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and ba and addr are zero.
- R2: Start high at a clock edge while idle drives cke high from that edge onward. Start is ignored once accepted, both while running and after done, and the command schedule does not change.
- R3: Command codes on {ras_n,cas_n,we_n}, with cs_n=0 always, are: NOP 111, precharge-all 010, auto refresh 001, mode/extended write 000. Every cycle that is not a command cycle is NOP.
- R4: The eleven commands appear in this order, with this bank select: precharge-all; extended write ba=10; extended write ba=11; extended write ba=01 (DLL on); mode write ba=00 (DLL reset); precharge-all; refresh; refresh; mode write ba=00; extended write ba=01 (calibration default); extended write ba=01 (calibration exit).
- R5: The first command issues exactly t_pwr_cyc cycles after the edge that raised cke. odt is low at every cycle.
- R6: Each later command issues exactly one gap after the previous command. The gap is t_rp_cyc after a precharge-all, t_mrd_cyc after any mode or extended write, and t_rfc_cyc after a refresh. A count of zero acts as one.
- R7: A precharge-all drives only addr bit 10 high, with ba=00. A refresh drives addr and ba as zero.
- R8: A mode write drives mr_word with bit 7 and bit 13 cleared. Bit 8 is forced to 1 on the first mode write and to 0 on the second.
- R9: Every extended write with ba=01 drives emr1_word with bit 0 and bit 13 cleared. Bits 9:7 are 000 on the first and last such write and 111 on the calibration-default write.
- R10: Extended writes with ba=10 and ba=11 drive emr2_word and emr3_word with bit 13 cleared. Bit 13 of addr is low at every cycle.
- R11: done rises at the later of two edges: the last command plus t_mrd_cyc, or the DLL-reset mode write plus DLL_LOCK_CYC. Once high, done stays high and the bus stays NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| t_pwr_cyc | input | CNT_W | NOP cycles between cke rising and the first command |
| t_rp_cyc | input | CNT_W | Gap after precharge-all |
| t_mrd_cyc | input | CNT_W | Gap after a mode or extended write |
| t_rfc_cyc | input | CNT_W | Gap after auto refresh |
| emr1_word | input | ADDR_W | Payload for extended register 1 |
| emr2_word | input | ADDR_W | Payload for extended register 2 |
| emr3_word | input | ADDR_W | Payload for extended register 3 |
| mr_word | input | ADDR_W | Payload for the mode register |
| cke | output | 1 | Clock enable |
| odt | output | 1 | On-die termination, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address / mode payload |
| done | output | 1 | Sequence complete |

## Verification
The bound checker watches on every cycle that only the four legal command codes appear on the bus. It also checks that no command comes sooner than the gap owed to the previous one, that precharge carries bit 10, and that the test-mode and top address bits stay low. It confirms that cke and done never fall once raised, and that done never rises before the DLL lock window has elapsed since the DLL-reset write. Only the bench scenarios can show what the checker cannot: the exact command order, exact (not minimum) spacing, the merged payload values for all-ones and all-zero words, which of the two limits sets the done edge, and that a start pulse mid-run or after done changes nothing.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PREA,
    CMD_REF,
    CMD_MRW
  } cmd_e;

  typedef enum logic [1:0] {
    GAP_PWR,
    GAP_RP,
    GAP_MRD,
    GAP_RFC
  } gap_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam int STEP_W    = 4;
  localparam int LAST_STEP = 11;
  localparam int DLL_STEP  = 5;

  function automatic pins_t encode_cmd(cmd_e c);
    pins_t p;
    case (c)
      CMD_PREA: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRW:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (val == '0) ? '0 : val - W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_step_dec.sv
module ddr2_init_step_dec
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] emr1_word,
  input  logic [ADDR_W-1:0] emr2_word,
  input  logic [ADDR_W-1:0] emr3_word,
  input  logic [ADDR_W-1:0] mr_word,
  output cmd_e              cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output gap_e              gap
);

  localparam int TOP_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] M_TOP    = ADDR_W'(1) << TOP_BIT;
  localparam logic [ADDR_W-1:0] M_AP     = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] M_DLLOFF = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] M_OCD    = ADDR_W'(7) << 7;
  localparam logic [ADDR_W-1:0] M_TM     = ADDR_W'(1) << 7;
  localparam logic [ADDR_W-1:0] M_RST    = ADDR_W'(1) << 8;

  always_comb begin
    cmd  = CMD_NOP;
    ba   = 2'b00;
    addr = '0;
    gap  = GAP_MRD;
    case (step)
      4'd0: gap = GAP_PWR;
      4'd1, 4'd6: begin
        cmd  = CMD_PREA;
        addr = M_AP;
        gap  = GAP_RP;
      end
      4'd2: begin
        cmd  = CMD_MRW;
        ba   = 2'b10;
        addr = emr2_word & ~M_TOP;
      end
      4'd3: begin
        cmd  = CMD_MRW;
        ba   = 2'b11;
        addr = emr3_word & ~M_TOP;
      end
      4'd4, 4'd11: begin
        cmd  = CMD_MRW;
        ba   = 2'b01;
        addr = emr1_word & ~(M_TOP | M_DLLOFF | M_OCD);
      end
      4'd5: begin
        cmd  = CMD_MRW;
        addr = (mr_word & ~(M_TOP | M_TM)) | M_RST;
      end
      4'd7, 4'd8: begin
        cmd = CMD_REF;
        gap = GAP_RFC;
      end
      4'd9: begin
        cmd  = CMD_MRW;
        addr = mr_word & ~(M_TOP | M_TM | M_RST);
      end
      4'd10: begin
        cmd  = CMD_MRW;
        ba   = 2'b01;
        addr = (emr1_word & ~(M_TOP | M_DLLOFF)) | M_OCD;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int ADDR_W       = 14,
  parameter int DLL_LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  t_pwr_cyc,
  input  logic [CNT_W-1:0]  t_rp_cyc,
  input  logic [CNT_W-1:0]  t_mrd_cyc,
  input  logic [CNT_W-1:0]  t_rfc_cyc,
  input  logic [ADDR_W-1:0] emr1_word,
  input  logic [ADDR_W-1:0] emr2_word,
  input  logic [ADDR_W-1:0] emr3_word,
  input  logic [ADDR_W-1:0] mr_word,
  output logic              cke,
  output logic              odt,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int DLL_W = $clog2(DLL_LOCK_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] nxt_step;
  pins_t             pins_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cke_q;
  logic              done_q;

  cmd_e              dec_cmd;
  logic [1:0]        dec_ba;
  logic [ADDR_W-1:0] dec_addr;
  gap_e              dec_gap;
  logic [CNT_W-1:0]  gap_val;
  logic              gap_exp;
  logic              dll_exp;
  logic              advance;
  logic              finish;

  assign nxt_step = (state_q == ST_IDLE) ? '0 : step_q + STEP_W'(1);

  ddr2_init_step_dec #(.ADDR_W(ADDR_W)) dec_i (
    .step      (nxt_step),
    .emr1_word (emr1_word),
    .emr2_word (emr2_word),
    .emr3_word (emr3_word),
    .mr_word   (mr_word),
    .cmd       (dec_cmd),
    .ba        (dec_ba),
    .addr      (dec_addr),
    .gap       (dec_gap)
  );

  always_comb begin
    case (dec_gap)
      GAP_PWR: gap_val = t_pwr_cyc;
      GAP_RP:  gap_val = t_rp_cyc;
      GAP_RFC: gap_val = t_rfc_cyc;
      default: gap_val = t_mrd_cyc;
    endcase
  end

  assign advance = ((state_q == ST_IDLE) && start) ||
                   ((state_q == ST_RUN) && gap_exp && (step_q != STEP_W'(LAST_STEP)));
  assign finish  = (state_q == ST_RUN) && gap_exp && dll_exp &&
                   (step_q == STEP_W'(LAST_STEP));

  ddr2_init_timer #(.W(CNT_W)) gap_tmr_i (
    .clk     (clk),
    .rst     (rst),
    .load    (advance),
    .val     (gap_val),
    .expired (gap_exp)
  );

  ddr2_init_timer #(.W(DLL_W)) dll_tmr_i (
    .clk     (clk),
    .rst     (rst),
    .load    (advance && (nxt_step == STEP_W'(DLL_STEP))),
    .val     (DLL_W'(DLL_LOCK_CYC)),
    .expired (dll_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      pins_q  <= encode_cmd(CMD_NOP);
      ba_q    <= 2'b00;
      addr_q  <= '0;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      pins_q <= encode_cmd(CMD_NOP);
      ba_q   <= 2'b00;
      addr_q <= '0;
      if (advance) begin
        state_q <= ST_RUN;
        step_q  <= nxt_step;
        cke_q   <= 1'b1;
        pins_q  <= encode_cmd(dec_cmd);
        ba_q    <= dec_ba;
        addr_q  <= dec_addr;
      end
      if (finish) begin
        state_q <= ST_DONE;
        done_q  <= 1'b1;
      end
    end
  end

  assign cke   = cke_q;
  assign odt   = 1'b0;
  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
  assign ba    = ba_q;
  assign addr  = addr_q;
  assign done  = done_q;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int CNT_W        = 16,
  parameter int ADDR_W       = 14,
  parameter int DLL_LOCK_CYC = 200
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  t_pwr_cyc,
  input logic [CNT_W-1:0]  t_rp_cyc,
  input logic [CNT_W-1:0]  t_mrd_cyc,
  input logic [CNT_W-1:0]  t_rfc_cyc,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);

  localparam int SW = CNT_W + 1;
  localparam int DW = $clog2(DLL_LOCK_CYC + 1) + 1;
  localparam logic [2:0] K_NONE = 3'd0, K_PWR = 3'd1, K_PRE = 3'd2,
                         K_MRW = 3'd3, K_REF = 3'd4;

  logic [2:0]    code;
  logic          is_cmd;
  logic [2:0]    kind_q;
  logic [SW-1:0] since_q;
  logic [SW-1:0] req_gap;
  logic [DW-1:0] dll_q;
  logic          dll_armed_q;
  logic          cke_d;

  assign code   = {ras_n, cas_n, we_n};
  assign is_cmd = (code != 3'b111);

  always_comb begin
    case (kind_q)
      K_PWR:   req_gap = SW'(t_pwr_cyc);
      K_PRE:   req_gap = SW'(t_rp_cyc);
      K_MRW:   req_gap = SW'(t_mrd_cyc);
      K_REF:   req_gap = SW'(t_rfc_cyc);
      default: req_gap = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q      <= K_NONE;
      since_q     <= '0;
      dll_q       <= '0;
      dll_armed_q <= 1'b0;
      cke_d       <= 1'b0;
    end else begin
      cke_d <= cke;
      if (is_cmd) begin
        since_q <= SW'(1);
        kind_q  <= (code == 3'b010) ? K_PRE : (code == 3'b001) ? K_REF : K_MRW;
      end else if (cke && !cke_d) begin
        since_q <= SW'(1);
        kind_q  <= K_PWR;
      end else if (since_q != '1) begin
        since_q <= since_q + SW'(1);
      end
      if (code == 3'b000 && ba == 2'b00 && addr[8]) begin
        dll_q       <= DW'(1);
        dll_armed_q <= 1'b1;
      end else if (dll_q != '1) begin
        dll_q <= dll_q + DW'(1);
      end
    end
  end

  // R3: only the four legal codes with chip select low
  assert_cmd_code_R3: assert property (@(posedge clk) disable iff (rst)
    !cs_n && (code == 3'b111 || code == 3'b010 || code == 3'b001 || code == 3'b000));

  // R6 (and R5 for the first command): no command before its gap
  assert_gap_min_R6: assert property (@(posedge clk) disable iff (rst)
    is_cmd |-> (cke && kind_q != K_NONE && since_q >= req_gap));

  assert_prea_ap_R7: assert property (@(posedge clk) disable iff (rst)
    (code == 3'b010) |-> (addr[10] && ba == 2'b00));

  assert_mrs_tm_low_R8: assert property (@(posedge clk) disable iff (rst)
    (code == 3'b000 && ba == 2'b00) |-> !addr[7]);

  // R10: top address bit never driven
  assert_a13_low_R10: assert property (@(posedge clk) disable iff (rst)
    !addr[ADDR_W-1]);

  assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_done_dll_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (dll_armed_q && dll_q >= DW'(DLL_LOCK_CYC)));

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !is_cmd);

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DLL_LOCK_CYC(DLL_LOCK_CYC)
) chk_i (
  .clk(clk), .rst(rst),
  .t_pwr_cyc(t_pwr_cyc), .t_rp_cyc(t_rp_cyc), .t_mrd_cyc(t_mrd_cyc), .t_rfc_cyc(t_rfc_cyc),
  .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .addr(addr), .done(done)
);

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_tb_top;

  localparam int CW  = 16;
  localparam int AW  = 14;
  localparam int DLL = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] t_pwr = 1, t_rp = 1, t_mrd = 1, t_rfc = 1;
  logic [AW-1:0] emr1 = '0, emr2 = '0, emr3 = '0, mr = '0;
  logic cke, odt, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_init_seq #(.CNT_W(CW), .ADDR_W(AW), .DLL_LOCK_CYC(DLL)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .t_pwr_cyc(t_pwr), .t_rp_cyc(t_rp), .t_mrd_cyc(t_mrd), .t_rfc_cyc(t_rfc),
    .emr1_word(emr1), .emr2_word(emr2), .emr3_word(emr3), .mr_word(mr),
    .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected {code[2:0], ba[1:0], addr} for command k
  function automatic logic [31:0] exp_cmd(input int k);
    logic [AW-1:0] top = 14'h2000;
    logic [2:0] c;
    logic [1:0] b;
    logic [AW-1:0] a;
    c = 3'b000; b = 2'b00; a = '0;
    case (k)
      0, 5: begin c = 3'b010; a = 14'h0400; end
      1: begin b = 2'b10; a = emr2 & ~top; end
      2: begin b = 2'b11; a = emr3 & ~top; end
      3, 10: begin b = 2'b01; a = emr1 & ~(top | 14'h0381); end
      4: a = (mr & ~(top | 14'h0080)) | 14'h0100;
      6, 7: c = 3'b001;
      8: a = mr & ~(top | 14'h0180);
      9: begin b = 2'b01; a = (emr1 & ~(top | 14'h0001)) | 14'h0380; end
      default: ;
    endcase
    return {13'd0, c, b, a};
  endfunction

  function automatic int gap_after(input int k);
    if (k == 0 || k == 5) return eff(int'(t_rp));
    if (k == 6 || k == 7) return eff(int'(t_rfc));
    return eff(int'(t_mrd));
  endfunction

  task automatic run_case(input int pw, input int rp, input int md, input int rf,
                          input int pat, input bit poke);
    int e0, n, td, et, dll_t, exp_done;
    int tk[11];
    logic [31:0] got[11];
    bit aux_bad;
    rst = 1'b1; start = 1'b0;
    t_pwr = CW'(pw); t_rp = CW'(rp); t_mrd = CW'(md); t_rfc = CW'(rf);
    case (pat)
      0: begin emr1 = '1; emr2 = '1; emr3 = '1; mr = '1; end
      1: begin emr1 = '0; emr2 = '0; emr3 = '0; mr = '0; end
      default: begin emr1 = 14'h2A5C; emr2 = 14'h1234; emr3 = 14'h3003; mr = 14'h35B2; end
    endcase
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: idle state after reset
    chk("R1 reset/idle outputs", {9'd0, cke, done, odt, cs_n, ras_n, cas_n, we_n, ba, addr},
        {9'd0, 3'b000, 4'b0111, 2'b00, 14'd0});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e0 = cyc;
    chk("R2 cke rises on start", {31'd0, cke}, 32'd1);
    n = 0; td = -1; aux_bad = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = poke && (i == 3 || i == 40);
      if (cs_n !== 1'b0 || odt !== 1'b0 || cke !== 1'b1) aux_bad = 1'b1;
      if ({ras_n, cas_n, we_n} !== 3'b111 && n < 11) begin
        tk[n]  = cyc - e0;
        got[n] = {13'd0, ras_n, cas_n, we_n, ba, addr};
        n++;
      end
      if (done === 1'b1) begin td = cyc - e0; break; end
    end
    start = 1'b0;
    chk("R4 eleven commands issued", n, 11);
    chk("R5 odt low, cs_n low, cke high during run", {31'd0, aux_bad}, 32'd0);
    et = eff(pw);
    dll_t = 0;
    for (int k = 0; k < 11; k++) begin
      if (k < n) begin
        chk(k == 0 ? "R5 first command time" : "R6 command spacing", tk[k], et);
        chk((k == 0 || k == 5 || k == 6 || k == 7) ? "R7 precharge/refresh code and address" :
            (k == 4 || k == 8) ? "R8 mode write payload" :
            (k == 3 || k == 9 || k == 10) ? "R9 ext1 payload" : "R10 ext2/3 payload",
            got[k], exp_cmd(k));
      end
      if (k == 4) dll_t = et;
      if (k < 10) et += gap_after(k);
    end
    exp_done = et + eff(md);
    if (dll_t + DLL > exp_done) exp_done = dll_t + DLL;
    chk("R11 done edge", td, exp_done);
    aux_bad = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = poke && (i == 1);
      if (done !== 1'b1 || {cs_n, ras_n, cas_n, we_n} !== 4'b0111 || cke !== 1'b1) aux_bad = 1'b1;
    end
    start = 1'b0;
    chk(poke ? "R2 start after done ignored, R11 done held" : "R11 done held, bus NOP",
        {31'd0, aux_bad}, 32'd0);
  endtask

  initial begin
    int idx;
    idx = 0;
    for (int pw = 1; pw <= 6; pw += 5)
      for (int rp = 0; rp <= 2; rp += 2)
        for (int mi = 0; mi < 3; mi++)
          for (int rf = 1; rf <= 40; rf += 39) begin
            run_case(pw, rp, (mi == 0) ? 1 : (mi == 1) ? 3 : 90, rf, idx % 3, (idx % 4) == 1);
            idx++;
          end
    run_case(0, 0, 0, 0, 0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule